// File: doc/BRIEF.md
# USB Packet Field Decoder

This block sits behind the line-level receiver of a full-speed USB port. It takes the bit stream of one packet, after NRZI decoding and after stuffed bits have been removed, one bit per strobe, least significant bit first. It checks the synchronisation byte and turns the packet identifier into a type code. It then pulls out the fields that belong to that type: device address and endpoint for tokens, frame number for start-of-frame, and payload bytes for data packets. Handshake packets and unknown identifiers carry no fields.

Payload bytes pass through a short holding line. A byte is released only once the bits that follow it are certain to include the whole trailing 16-bit check code. As a result the check code never reaches the byte stream, and the final payload byte is marked as last. A summary pulse after end-of-packet reports the type code, the raw identifier byte, the token or frame fields, and two error flags. The flags mark a bad synchronisation byte and a packet whose length does not fit its type. Checking the CRC itself, ordering transactions and tracking data toggles are left to other blocks.

A packet is framed by a one-cycle `pkt_start` strobe and a one-cycle `pkt_end` strobe. Neither strobe coincides with a bit strobe. Any number of idle cycles may fall between bits.

Top module: `usb_pkt_field_dec`

## Requirements
- R1: After reset, and between packets, `pkt_done`, `byte_vld`, `byte_last`, `sync_err` and `len_err` are 0.
- R2: `sync_err` is 0 only when the first 8 bits received are seven 0s followed by a 1, i.e. the byte 0x80 assembled LSB first. A packet shorter than 8 bits sets `sync_err`. The rest of the decode proceeds regardless.
- R3: Bits 8 to 15 form the identifier byte `pid_raw`, with bit 8 as its LSB. `pkt_type` codes: OUT 0xE1→0, IN 0x69→1, SOF 0xA5→2, SETUP 0x2D→3, DATA0 0xC3→4, DATA1 0x4B→5, ACK 0xD2→6, NAK 0x5A→7, STALL 0x1E→8, NYET 0x96→9. Any other byte, or a packet with fewer than 16 bits, gives 15, with `pid_raw` holding the bits received (0 for bits not received).
- R4: For types 0, 1 and 3, `dev_addr` holds bits 16 to 22 and `endp` holds bits 23 to 26, each LSB first. For all other types both are 0.
- R5: For type 2, `frame_no` holds bits 16 to 26, LSB first. For all other types it is 0.
- R6: For types 4 and 5, the bits after the identifier are grouped into bytes, LSB first. The last two complete bytes are never output. Each other byte appears once on `byte_data` with `byte_vld`, in order.
- R7: In a data packet whose length after the identifier is a whole number of bytes and at least 24 bits, the final released byte carries `byte_last` in the cycle after `pkt_end`. No other byte carries it. A data packet with only 16 bits after the identifier releases no byte.
- R8: `len_err` is set when the packet has fewer than 16 bits. It is also set when, after the identifier, a token or SOF has other than 16 bits, a data packet has fewer than 16 bits or a count not divisible by 8, or a handshake (types 6 to 9) has any bits. On a data packet with a partial final byte, bytes are released only while three complete bytes follow them, and no byte carries `byte_last`.
- R9: `pkt_done` pulses for one cycle, exactly one cycle after `pkt_end`, with all summary outputs valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | One-cycle strobe before the first bit of a packet |
| pkt_end | input | 1 | One-cycle strobe after the last bit of a packet |
| bit_vld | input | 1 | Strobe for one received, unstuffed bit |
| bit_val | input | 1 | Value of the received bit |
| pkt_done | output | 1 | One-cycle packet summary strobe |
| pkt_type | output | 4 | Packet type code (see R3) |
| pid_raw | output | 8 | Identifier byte as received |
| dev_addr | output | 7 | Token device address |
| endp | output | 4 | Token endpoint number |
| frame_no | output | 11 | Start-of-frame frame number |
| sync_err | output | 1 | Synchronisation byte was wrong or missing |
| len_err | output | 1 | Packet length does not fit its type |
| byte_vld | output | 1 | Payload byte valid |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Final payload byte of the packet |

## Verification
Random packets of every identifier type are sent, along with unknown identifiers. Their field and payload values are random, idle gaps of random length fall between bits, and some packets have a corrupted sync bit or a length stretched or cut by a few bits. Comparing their outputs separates correct type decoding from field extraction and from the release and length rules. Directed cases cover the edges: a data packet carrying only its check code, one with exactly one payload byte, a packet cut inside the identifier, one cut inside the sync byte, and a handshake with stray bits. These show whether the holding line drops exactly two bytes and whether the shortest packets are flagged instead of being misread.

// File: rtl/usb_fd_pkg.sv
package usb_fd_pkg;

  localparam int SYNC_W   = 8;
  localparam int PID_W    = 8;
  localparam int HDR_W    = SYNC_W + PID_W;
  localparam int TOKCRC_W = 5;
  localparam int DATCRC_W = 16;
  localparam int ADDR_W   = 7;
  localparam int ENDP_W   = 4;
  localparam int FLD_W    = ADDR_W + ENDP_W;
  localparam int TOKBODY_W = FLD_W + TOKCRC_W;
  localparam logic [SYNC_W-1:0] SYNC_BYTE = 8'h80;

  typedef enum logic [3:0] {
    PT_OUT   = 4'd0,
    PT_IN    = 4'd1,
    PT_SOF   = 4'd2,
    PT_SETUP = 4'd3,
    PT_DATA0 = 4'd4,
    PT_DATA1 = 4'd5,
    PT_ACK   = 4'd6,
    PT_NAK   = 4'd7,
    PT_STALL = 4'd8,
    PT_NYET  = 4'd9,
    PT_BAD   = 4'd15
  } pkt_type_e;

  function automatic pkt_type_e pid_to_type(input logic [PID_W-1:0] pid);
    case (pid)
      8'hE1:   return PT_OUT;
      8'h69:   return PT_IN;
      8'hA5:   return PT_SOF;
      8'h2D:   return PT_SETUP;
      8'hC3:   return PT_DATA0;
      8'h4B:   return PT_DATA1;
      8'hD2:   return PT_ACK;
      8'h5A:   return PT_NAK;
      8'h1E:   return PT_STALL;
      8'h96:   return PT_NYET;
      default: return PT_BAD;
    endcase
  endfunction

  function automatic logic is_token(input pkt_type_e t);
    return (t == PT_OUT) || (t == PT_IN) || (t == PT_SETUP);
  endfunction

  function automatic logic is_data(input pkt_type_e t);
    return (t == PT_DATA0) || (t == PT_DATA1);
  endfunction

  function automatic logic is_hshk(input pkt_type_e t);
    return (t == PT_ACK) || (t == PT_NAK) || (t == PT_STALL) || (t == PT_NYET);
  endfunction

  // Length rule: nafter is the bit count after the identifier.
  function automatic logic len_bad(input pkt_type_e t, input logic hdr_full,
                                   input int unsigned nafter);
    if (!hdr_full)                      return 1'b1;
    if (is_token(t) || t == PT_SOF)     return nafter != TOKBODY_W;
    if (is_data(t))                     return (nafter < DATCRC_W) || (nafter % 8 != 0);
    if (is_hshk(t))                     return nafter != 0;
    return 1'b0;
  endfunction

endpackage

// File: rtl/usb_fd_hdr.sv
module usb_fd_hdr
  import usb_fd_pkg::*;
#(
  parameter int CNT_W = 13
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] bcnt,
  output logic             hdr_full,
  output logic             sync_ok,
  output logic [PID_W-1:0] pid,
  output pkt_type_e        ptype
);

  logic [HDR_W-1:0] hdr;
  logic             hdr_wr;

  assign hdr_full = (bcnt >= CNT_W'(HDR_W));
  assign hdr_wr   = bit_vld && !hdr_full;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hdr <= '0;
    end else if (hdr_wr) begin
      hdr[bcnt[$clog2(HDR_W)-1:0]] <= bit_val;
    end
  end

  assign sync_ok = (bcnt >= CNT_W'(SYNC_W)) && (hdr[SYNC_W-1:0] == SYNC_BYTE);
  assign pid     = hdr[HDR_W-1:SYNC_W];
  assign ptype   = hdr_full ? pid_to_type(pid) : PT_BAD;

  // R3
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_full && !clr) |=> $stable(hdr))
    else $error("header changed after it was complete");

endmodule

// File: rtl/usb_fd_tok.sv
module usb_fd_tok
  import usb_fd_pkg::*;
#(
  parameter int CNT_W = 13
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] bcnt,
  output logic [FLD_W-1:0] fld
);

  localparam int FIRST = HDR_W;
  localparam int LAST  = HDR_W + FLD_W - 1;

  logic             in_win;
  logic [CNT_W-1:0] idx;

  assign in_win = bit_vld && (bcnt >= CNT_W'(FIRST)) && (bcnt <= CNT_W'(LAST));
  assign idx    = bcnt - CNT_W'(FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fld <= '0;
    end else if (in_win) begin
      fld[idx[$clog2(FLD_W)-1:0]] <= bit_val;
    end
  end

  // R4
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt > CNT_W'(LAST) && !clr) |=> $stable(fld))
    else $error("field bits changed outside their window");

endmodule

// File: rtl/usb_fd_pay.sv
module usb_fd_pay #(
  parameter int DW    = 8,
  parameter int CRC_W = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pbit_vld,
  input  logic          bit_val,
  input  logic          byte_end,
  input  logic          fin,
  output logic          byte_vld,
  output logic [DW-1:0] byte_data,
  output logic          byte_last
);

  localparam int HOLD  = CRC_W / DW + 1;
  localparam int HC_W  = $clog2(HOLD + 1);

  logic [DW-1:0] asm_q;
  logic [DW-1:0] nbyte;
  logic [DW-1:0] slot [HOLD];
  logic [HC_W-1:0] hcnt;
  logic          full;
  logic          push;

  assign nbyte = {bit_val, asm_q[DW-1:1]};
  assign full  = (hcnt == HC_W'(HOLD));
  assign push  = pbit_vld && byte_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      asm_q <= '0;
    end else if (pbit_vld) begin
      asm_q <= nbyte;
    end
  end

  generate
    for (genvar g = 0; g < HOLD; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          slot[g] <= '0;
        end else if (push) begin
          if (full) begin
            if (g == HOLD - 1) slot[g] <= nbyte;
            else               slot[g] <= slot[(g + 1) % HOLD];
          end else if (hcnt == HC_W'(g)) begin
            slot[g] <= nbyte;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hcnt <= '0;
    end else if (push && !full) begin
      hcnt <= hcnt + HC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_vld  <= 1'b0;
      byte_last <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld  <= (push && full) || (fin && full);
      byte_last <= fin && full;
      byte_data <= slot[0];
    end
  end

  // R7
  last_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> byte_vld)
    else $error("last flag without a byte");

  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(full))
    else $error("byte released before holding line was full");

endmodule

// File: rtl/usb_pkt_field_dec.sv
module usb_pkt_field_dec
  import usb_fd_pkg::*;
#(
  parameter int CNT_W = 13
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic              pkt_done,
  output logic [3:0]        pkt_type,
  output logic [PID_W-1:0]  pid_raw,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [ENDP_W-1:0] endp,
  output logic [FLD_W-1:0]  frame_no,
  output logic              sync_err,
  output logic              len_err,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic              byte_last
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] bcnt;
  logic             hdr_full;
  logic             sync_ok;
  logic [PID_W-1:0] pid;
  pkt_type_e        ptype;
  logic [FLD_W-1:0] fld;
  logic             pbit_vld;
  logic             byte_end;
  logic             fin;
  logic             len_bad_w;
  logic [CNT_W-1:0] nafter;

  always_ff @(posedge clk) begin
    if (!rst_n || pkt_start) begin
      bcnt <= '0;
    end else if (bit_vld && bcnt != CNT_MAX) begin
      bcnt <= bcnt + CNT_W'(1);
    end
  end

  usb_fd_hdr #(.CNT_W(CNT_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start),
    .bit_vld(bit_vld), .bit_val(bit_val), .bcnt(bcnt),
    .hdr_full(hdr_full), .sync_ok(sync_ok), .pid(pid), .ptype(ptype)
  );

  usb_fd_tok #(.CNT_W(CNT_W)) u_tok (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start),
    .bit_vld(bit_vld), .bit_val(bit_val), .bcnt(bcnt), .fld(fld)
  );

  assign nafter   = hdr_full ? bcnt - CNT_W'(HDR_W) : '0;
  assign pbit_vld = bit_vld && hdr_full && is_data(ptype);
  assign byte_end = (bcnt[2:0] == 3'd7);
  assign fin      = pkt_end && is_data(ptype) && (nafter >= CNT_W'(8 + DATCRC_W))
                    && (bcnt[2:0] == 3'd0);
  assign len_bad_w = len_bad(ptype, hdr_full, int'(nafter));

  usb_fd_pay #(.DW(8), .CRC_W(DATCRC_W)) u_pay (
    .clk(clk), .rst_n(rst_n), .clr(pkt_start),
    .pbit_vld(pbit_vld), .bit_val(bit_val), .byte_end(byte_end), .fin(fin),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_last(byte_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done <= 1'b0;
      pkt_type <= PT_BAD;
      pid_raw  <= '0;
      dev_addr <= '0;
      endp     <= '0;
      frame_no <= '0;
      sync_err <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      pkt_done <= pkt_end;
      if (pkt_end) begin
        pkt_type <= ptype;
        pid_raw  <= pid;
        dev_addr <= is_token(ptype) ? fld[ADDR_W-1:0] : '0;
        endp     <= is_token(ptype) ? fld[FLD_W-1:ADDR_W] : '0;
        frame_no <= (ptype == PT_SOF) ? fld : '0;
        sync_err <= !sync_ok;
        len_err  <= len_bad_w;
      end else begin
        sync_err <= 1'b0;
        len_err  <= 1'b0;
      end
    end
  end

  // R9
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(pkt_end))
    else $error("summary without end of packet");

  // R4
  tok_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !is_token(pkt_type_e'(pkt_type))) |-> (dev_addr == '0 && endp == '0))
    else $error("token fields on a non-token packet");

  // R6
  pay_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> is_data($past(ptype)))
    else $error("payload byte outside a data packet");

  // R1
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |-> (!sync_err && !len_err))
    else $error("error flag outside summary cycle");

endmodule

// File: tb/sim_usb_pkt_field_dec.sv
module sim_usb_pkt_field_dec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 1'b0, pkt_end = 1'b0, bit_vld = 1'b0, bit_val = 1'b0;
  logic pkt_done, sync_err, len_err, byte_vld, byte_last;
  logic [3:0] pkt_type;
  logic [7:0] pid_raw, byte_data;
  logic [6:0] dev_addr;
  logic [3:0] endp;
  logic [10:0] frame_no;

  always #2 clk = ~clk;

  usb_pkt_field_dec u0 (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .bit_vld(bit_vld), .bit_val(bit_val), .pkt_done(pkt_done),
    .pkt_type(pkt_type), .pid_raw(pid_raw), .dev_addr(dev_addr), .endp(endp),
    .frame_no(frame_no), .sync_err(sync_err), .len_err(len_err),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_last(byte_last)
  );

  int n_chk = 0, n_fail = 0;
  logic pk [0:1023];
  int plen;

  // monitor
  logic [7:0] rxb [0:127];
  logic       rxl [0:127];
  int  rxn;
  int  done_cnt;
  logic [3:0] m_type; logic [7:0] m_pid; logic [6:0] m_addr; logic [3:0] m_endp;
  logic [10:0] m_frame; logic m_serr, m_lerr;
  int  end_cyc, done_cyc, last_cyc, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (byte_vld && rxn < 128) begin
      rxb[rxn] = byte_data; rxl[rxn] = byte_last; rxn++;
      if (byte_last) last_cyc = cyc;
    end
    if (pkt_done) begin
      done_cnt++; done_cyc = cyc;
      m_type = pkt_type; m_pid = pid_raw; m_addr = dev_addr; m_endp = endp;
      m_frame = frame_no; m_serr = sync_err; m_lerr = len_err;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int unsigned v, input int n);
    for (int i = 0; i < n; i++) begin pk[plen] = v[i]; plen++; end
  endtask

  function automatic int exp_type(input logic [7:0] p);
    int t;
    t = 15;
    if (p == 8'hE1) t = 0; if (p == 8'h69) t = 1; if (p == 8'hA5) t = 2;
    if (p == 8'h2D) t = 3; if (p == 8'hC3) t = 4; if (p == 8'h4B) t = 5;
    if (p == 8'hD2) t = 6; if (p == 8'h5A) t = 7; if (p == 8'h1E) t = 8;
    if (p == 8'h96) t = 9;
    return t;
  endfunction

  function automatic int bits_at(input int pos, input int n);
    int v;
    v = 0;
    for (int i = 0; i < n; i++)
      if (pos + i < plen && pk[pos + i]) v |= (1 << i);
    return v;
  endfunction

  task automatic send_and_check(input string tag);
    int t, na, nb, expn, gaps;
    logic el, es;
    logic [7:0] p;
    rxn = 0; done_cnt = 0; last_cyc = -1;
    @(negedge clk); pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0;
    for (int i = 0; i < plen; i++) begin
      bit_vld = 1'b1; bit_val = pk[i];
      @(negedge clk); bit_vld = 1'b0;
      gaps = ($urandom % 4 == 0) ? 1 + $urandom % 2 : 0;
      repeat (gaps) @(negedge clk);
    end
    pkt_end = 1'b1; end_cyc = cyc;
    @(negedge clk); pkt_end = 1'b0;
    repeat (3) @(negedge clk);
    // expected values from the requirements
    p  = 8'(bits_at(8, 8));
    t  = (plen < 16) ? 15 : exp_type(p);
    na = (plen >= 16) ? plen - 16 : 0;
    es = (plen < 8) || (bits_at(0, 8) != 8'h80);
    if (plen < 16) el = 1;
    else if (t <= 3) el = (na != 16);
    else if (t <= 5) el = (na < 16) || (na % 8 != 0);
    else if (t <= 9) el = (na != 0);
    else el = 0;
    nb = na / 8;
    if (t == 4 || t == 5) expn = (na % 8 == 0) ? ((nb >= 3) ? nb - 2 : 0)
                                              : ((nb >= 3) ? nb - 3 : 0);
    else expn = 0;
    // R9
    chk(done_cnt == 1 && done_cyc == end_cyc + 1, {"R9 done timing ", tag}, done_cyc, end_cyc + 1);
    // R3
    chk(m_type == 4'(t), {"R3 type ", tag}, m_type, t);
    chk(m_pid == p, {"R3 pid_raw ", tag}, m_pid, p);
    // R2
    chk(m_serr == es, {"R2 sync_err ", tag}, m_serr, es);
    // R8
    chk(m_lerr == el, {"R8 len_err ", tag}, m_lerr, el);
    // R4
    chk(m_addr == ((t == 0 || t == 1 || t == 3) ? 7'(bits_at(16, 7)) : 7'd0),
        {"R4 dev_addr ", tag}, m_addr, bits_at(16, 7));
    chk(m_endp == ((t == 0 || t == 1 || t == 3) ? 4'(bits_at(23, 4)) : 4'd0),
        {"R4 endp ", tag}, m_endp, bits_at(23, 4));
    // R5
    chk(m_frame == ((t == 2) ? 11'(bits_at(16, 11)) : 11'd0),
        {"R5 frame_no ", tag}, m_frame, bits_at(16, 11));
    // R6
    chk(rxn == expn, {"R6 byte count ", tag}, rxn, expn);
    for (int k = 0; k < rxn && k < expn; k++)
      chk(rxb[k] == 8'(bits_at(16 + 8 * k, 8)), {"R6 byte value ", tag}, rxb[k], bits_at(16 + 8 * k, 8));
    // R7
    for (int k = 0; k < rxn; k++) begin
      logic lx;
      lx = (k == expn - 1) && (na % 8 == 0) && (t == 4 || t == 5);
      chk(rxl[k] == lx, {"R7 last flag ", tag}, rxl[k], lx);
    end
    if (expn > 0 && na % 8 == 0)
      chk(last_cyc == end_cyc + 1, {"R7 last timing ", tag}, last_cyc, end_cyc + 1);
    // R1
    chk(!pkt_done && !byte_vld && !sync_err && !len_err, {"R1 idle ", tag},
        {pkt_done, byte_vld, sync_err, len_err}, 0);
  endtask

  task automatic hdr(input logic [7:0] pid);
    plen = 0; push(32'h80, 8); push(pid, 8);
  endtask

  localparam logic [7:0] PIDS [0:9] = '{8'hE1, 8'h69, 8'hA5, 8'h2D, 8'hC3,
                                         8'h4B, 8'hD2, 8'h5A, 8'h1E, 8'h96};

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!pkt_done && !byte_vld && !byte_last && !sync_err && !len_err, "R1 reset",
        {pkt_done, byte_vld, byte_last, sync_err, len_err}, 0);

    // directed corners
    hdr(8'hC3); push($urandom, 16); send_and_check("data crc only");
    hdr(8'h4B); push(8'h5C, 8); push($urandom, 16); send_and_check("data one byte");
    hdr(8'hE1); push(7'h55, 7); push(4'hA, 4); push($urandom, 5); send_and_check("out token");
    hdr(8'hA5); push(11'h7FF, 11); push($urandom, 5); send_and_check("sof max");
    plen = 0; push(32'h80, 8); push(8'hE1, 4); send_and_check("cut in pid");
    plen = 0; push(32'h00, 5); send_and_check("cut in sync");
    hdr(8'hD2); push(3'b101, 3); send_and_check("hshk stray");
    hdr(8'h00); push($urandom, 9); send_and_check("bad pid");
    hdr(8'hC3); for (int i = 0; i < 6; i++) push($urandom, 8); push($urandom, 3);
    send_and_check("data partial byte");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int kind, delta;
      kind = $urandom % 11;
      hdr(kind < 10 ? PIDS[kind] : 8'($urandom));
      if (kind <= 3) push($urandom, 16);
      else if (kind <= 5) begin
        int nbytes;
        nbytes = $urandom % 7;
        for (int i = 0; i < nbytes; i++) push($urandom, 8);
        push($urandom, 16);
      end
      if ($urandom % 8 == 0) pk[$urandom % 8] ^= 1'b1;
      if ($urandom % 8 == 0) begin
        delta = 1 + $urandom % 5;
        if ($urandom % 2 == 0 && plen > delta) plen -= delta;
        else push($urandom, delta);
      end
      send_and_check("random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule